// File: doc/BRIEF.md
# Dual-Section Falling-Edge Binary Counter

This block is a four-stage binary counter made of two sections that run from one fast system clock. The low section is a single toggle stage, q_a. The high section is a three-bit binary counter on q_hi, with bit 0 as its least significant bit. Each section has its own count input. The block samples each count input through a synchronizer and advances the section on a detected high-to-low transition of that input. Rising transitions are ignored.

A cascade-select input lets the falling edge of q_a drive the high section. The high section's own count input is then ignored, and the four outputs together count 0 to 15, dividing the low input by 2, 4, 8 and 16. With the cascade off, the two sections are independent. The high section divides its own input by 2, 4 and 8, and the toggle stage is free for separate use. It still shares the common clear.

Two clear inputs are combined with AND. Only when both are high do all four outputs drop to zero at once, without waiting for a clock edge. Clock-synchronous release of the clear lets counting restart cleanly from zero.

Top module: `dual_section_counter`

## Requirements
- R1: While clr_a and clr_b are both high, q_a and q_hi are zero, and they go to zero before the next system clock edge.
- R2: With only one of clr_a or clr_b high, nothing is cleared and counting continues.
- R3: q_a toggles once for each high-to-low transition of cnt_a_in. A low-to-high transition of cnt_a_in leaves q_a unchanged.
- R4: With cascade_en low, q_hi increments by one on each high-to-low transition of cnt_b_in and wraps from 7 to 0.
- R5: With cascade_en high, q_hi increments on each 1-to-0 change of q_a and ignores cnt_b_in. The value {q_hi, q_a} then steps through 0 to 15 and wraps.
- R6: With cascade_en high, q_hi changes exactly one system clock after the clock edge at which q_a falls.
- R7: With cascade_en low, activity on cnt_a_in does not change q_hi, and activity on cnt_b_in does not change q_a.
- R8: After the clear is released, the first falling count edge takes the section from zero to one.
- R9: A section output changes on the third rising system clock edge after its count input falls, given two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_a | input | 1 | First clear input; clears only together with clr_b |
| clr_b | input | 1 | Second clear input; clears only together with clr_a |
| cnt_a_in | input | 1 | Count input of the toggle section |
| cnt_b_in | input | 1 | Count input of the three-bit section |
| cascade_en | input | 1 | 1: q_a falling edges advance the high section |
| q_a | output | 1 | Toggle section output (divide by two) |
| q_hi | output | HI_BITS | High section count, bit 0 least significant |

## Verification
The assertions assume three things. Each count input holds every level for at least SYNC_STAGES+1 system clocks. cascade_en does not change while a cascaded advance is pending. The clear inputs change away from rising clock edges. The bench keeps within these limits. It drives every input on the falling clock edge, holds each count level for six clocks, and changes cascade_en only while both sections are idle. The clear tests use mid-count values, and they pulse one clear input at a time to show that a lone clear has no effect.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int DSC_SYNC_MIN = 2;
   typedef enum logic {
      MODE_SPLIT = 1'b0,
      MODE_CHAIN = 1'b1
   } dsc_mode_e;
endpackage

// File: rtl/dsc_clr_sync.sv
module dsc_clr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr_req,
   output logic rst_out
);
   generate
      if (STAGES < dsc_pkg::DSC_SYNC_MIN) begin : g_bad
         $error("dsc_clr_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] hold_q;

   always_ff @(posedge clk or posedge clr_req) begin
      if (clr_req) hold_q <= '1;
      else         hold_q <= {hold_q[STAGES-2:0], 1'b0};
   end

   assign rst_out = hold_q[STAGES-1];

   AST_CLR_ASSERTED: assert property (@(posedge clk) clr_req |-> rst_out); // R1
endmodule

// File: rtl/dsc_edge_sync.sv
module dsc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic fall
);
   generate
      if (STAGES < dsc_pkg::DSC_SYNC_MIN) begin : g_bad
         $error("dsc_edge_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~chain_q[STAGES-1];

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall); // R3
endmodule

// File: rtl/dsc_stage.sv
module dsc_stage #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [WIDTH-1:0] cnt
);
   generate
      if (WIDTH < 1) begin : g_bad
         $error("dsc_stage: WIDTH must be positive");
      end
      if (WIDTH == 1) begin : g_toggle
         always_ff @(posedge clk or posedge rst) begin
            if (rst)      cnt <= '0;
            else if (adv) cnt <= ~cnt;
         end
      end else begin : g_binary
         always_ff @(posedge clk or posedge rst) begin
            if (rst)      cnt <= '0;
            else if (adv) cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      adv |=> cnt == WIDTH'($past(cnt) + 1'b1)); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt)); // R7
endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter #(
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2,
   parameter int HI_BITS     = 3
) (
   input  logic               clk,
   input  logic               clr_a,
   input  logic               clr_b,
   input  logic               cnt_a_in,
   input  logic               cnt_b_in,
   input  logic               cascade_en,
   output logic               q_a,
   output logic [HI_BITS-1:0] q_hi
);
   import dsc_pkg::*;

   generate
      if (HI_BITS < 1) begin : g_bad
         $error("dual_section_counter: HI_BITS must be positive");
      end
   endgenerate

   logic      clr_req;
   logic      rst_int;
   logic      fall_a;
   logic      fall_b;
   logic      qa_prev;
   logic      qa_fell;
   logic      hi_adv;
   logic [0:0] qa_vec;
   dsc_mode_e mode;

   assign clr_req = clr_a & clr_b;
   assign mode    = cascade_en ? MODE_CHAIN : MODE_SPLIT;

   dsc_clr_sync #(.STAGES(RST_STAGES)) u_clr (
      .clk(clk), .clr_req(clr_req), .rst_out(rst_int));

   dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst(rst_int), .din(cnt_a_in), .fall(fall_a));

   dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst(rst_int), .din(cnt_b_in), .fall(fall_b));

   dsc_stage #(.WIDTH(1)) u_low (
      .clk(clk), .rst(rst_int), .adv(fall_a), .cnt(qa_vec));

   assign q_a = qa_vec[0];

   always_ff @(posedge clk or posedge rst_int) begin
      if (rst_int) qa_prev <= 1'b0;
      else         qa_prev <= q_a;
   end

   assign qa_fell = qa_prev & ~q_a;
   assign hi_adv  = (mode == MODE_CHAIN) ? qa_fell : fall_b;

   dsc_stage #(.WIDTH(HI_BITS)) u_high (
      .clk(clk), .rst(rst_int), .adv(hi_adv), .cnt(q_hi));

   AST_CASCADE_LAG: assert property (@(posedge clk) disable iff (rst_int)
      (cascade_en && $fell(q_a)) |=> q_hi == HI_BITS'($past(q_hi) + 1'b1)); // R6
   AST_CASCADE_NO_B: assert property (@(posedge clk) disable iff (rst_int)
      (cascade_en && !$fell(q_a)) |=> $stable(q_hi)); // R5

   always_ff @(posedge clk) begin
      if (clr_a && clr_b) begin
         AST_CLEAR_ZERO: assert (q_a == 1'b0 && q_hi == '0); // R1
      end
   end
endmodule

// File: tb/tb_dual_section_counter.sv
module tb_dual_section_counter;
   logic       clk = 1'b0;
   logic       clr_a = 1'b1, clr_b = 1'b1;
   logic       cnt_a_in = 1'b0, cnt_b_in = 1'b0, cascade_en = 1'b0;
   logic       q_a;
   logic [2:0] q_hi;
   int         errors = 0, checks = 0;
   int         ref_a = 0, ref_b = 0;

   always #2 clk = ~clk;

   dual_section_counter dut (
      .clk(clk), .clr_a(clr_a), .clr_b(clr_b), .cnt_a_in(cnt_a_in),
      .cnt_b_in(cnt_b_in), .cascade_en(cascade_en), .q_a(q_a), .q_hi(q_hi));

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_a();
      cnt_a_in = 1'b1; idle(6);
      cnt_a_in = 1'b0; idle(6);
      if (ref_a == 1 && cascade_en) ref_b = (ref_b + 1) % 8;
      ref_a ^= 1;
   endtask

   task automatic pulse_b();
      cnt_b_in = 1'b1; idle(6);
      cnt_b_in = 1'b0; idle(6);
      if (!cascade_en) ref_b = (ref_b + 1) % 8;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_a = 1'b1; clr_b = 1'b1;
      #1;
      check("R1 async q_a", q_a, 0);
      check("R1 async q_hi", q_hi, 0);
      idle(3);
      clr_a = 1'b0; clr_b = 1'b0;
      idle(4);
      ref_a = 0; ref_b = 0;
   endtask

   task automatic t_reset_state();
      check("R1 reset q_a", q_a, 0);
      check("R1 reset q_hi", q_hi, 0);
      clr_a = 1'b0; clr_b = 1'b0;
      idle(4);
   endtask

   task automatic t_low_toggle();
      for (int i = 0; i < 3; i++) begin
         pulse_a();
         check("R3 toggle", q_a, ref_a);
         check("R7 q_hi untouched by A", q_hi, ref_b);
      end
      cnt_a_in = 1'b1; idle(6);
      check("R3 rising ignored", q_a, ref_a);
      cnt_a_in = 1'b0; idle(6);
      ref_a ^= 1;
      check("R3 falling after hold", q_a, ref_a);
   endtask

   task automatic t_latency();
      int seen = -1;
      cnt_a_in = 1'b1; idle(6);
      cnt_a_in = 1'b0;
      for (int i = 1; i <= 5; i++) begin
         @(posedge clk); #1;
         if (seen < 0 && q_a != ref_a) seen = i;
      end
      ref_a ^= 1;
      check("R9 edges to change", seen, 3);
      idle(4);
   endtask

   task automatic t_high_split();
      for (int i = 0; i < 9; i++) begin
         pulse_b();
         check("R4 split count", q_hi, ref_b);
         check("R7 q_a untouched by B", q_a, ref_a);
      end
   endtask

   task automatic t_cascade();
      do_clear();
      cascade_en = 1'b1;
      idle(2);
      pulse_b();
      check("R5 cnt_b ignored", q_hi, 0);
      for (int i = 1; i <= 17; i++) begin
         pulse_a();
         check("R5 chained value", {q_hi, q_a}, (ref_b << 1) | ref_a);
         check("R5 chained model", {q_hi, q_a}, i % 16);
      end
   endtask

   task automatic t_cascade_lag();
      int fall_edge = -1, hi_edge = -1;
      logic [2:0] hi0;
      if (ref_a == 0) pulse_a();
      hi0 = q_hi;
      cnt_a_in = 1'b1; idle(6);
      cnt_a_in = 1'b0;
      for (int i = 1; i <= 6; i++) begin
         @(posedge clk); #1;
         if (fall_edge < 0 && q_a == 1'b0) fall_edge = i;
         if (hi_edge < 0 && q_hi != hi0) hi_edge = i;
      end
      ref_a = 0; ref_b = (ref_b + 1) % 8;
      check("R6 cascade lag", hi_edge - fall_edge, 1);
      idle(4);
      check("R6 value after lag", q_hi, ref_b);
   endtask

   task automatic t_single_clear();
      int a0 = ref_a, b0 = ref_b;
      clr_a = 1'b1; idle(4);
      check("R2 clr_a alone q_a", q_a, a0);
      check("R2 clr_a alone q_hi", q_hi, b0);
      pulse_a();
      check("R2 counts under clr_a", {q_hi, q_a}, (ref_b << 1) | ref_a);
      clr_a = 1'b0; clr_b = 1'b1; idle(4);
      check("R2 clr_b alone", {q_hi, q_a}, (ref_b << 1) | ref_a);
      clr_b = 1'b0; idle(2);
   endtask

   task automatic t_restart();
      pulse_a(); pulse_a(); pulse_a();
      do_clear();
      cascade_en = 1'b0;
      pulse_b();
      check("R8 restart B", q_hi, 1);
      pulse_a();
      check("R8 restart A", q_a, 1);
   endtask

   initial begin
      idle(3);
      t_reset_state();
      t_low_toggle();
      t_latency();
      t_high_split();
      t_cascade();
      t_cascade_lag();
      t_single_clear();
      t_restart();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule